// File: doc/BRIEF.md
# E1 Per-Second Line Error Counters

This block keeps three running tallies of E1 line errors: bipolar violations, CRC4 sub-multiframe checksum errors and errors that the far end reports back through E-bits. Each source arrives as a one-cycle strobe from detection logic elsewhere in the receive path. Detecting the errors is not part of this block.

A free-running divider marks one-second boundaries on the line clock. At each boundary the three running tallies are copied into holding registers and restarted. A processor reading the holding registers therefore always sees the complete totals of the last finished second, however late in the current second it reads them. Each held total is presented as a high byte and a low byte for a byte-wide register bus. A one-cycle flag marks the first cycle in which fresh totals are visible.

The CRC4 and E-bit tallies only have meaning while the line runs CRC4 multiframing, so a mode input gates them. Every tally stops at its largest value instead of wrapping.

Top module: `line_err_counters`

## Requirements
- R1: While `rst_n` is low, and after release until the first boundary, all six count bytes read 0 and `sec_flag` is 0.
- R2: A boundary occurs every `TICK_DIV` clock cycles. `sec_flag` is high for exactly one cycle after each boundary, and that is the first cycle in which the new held totals are visible.
- R3: All three held totals change together, and only at a boundary. Between boundaries they keep the totals of the previous interval, and the running tallies restart from zero.
- R4: `bpv_err` adds one to the bipolar violation tally in every cycle it is high, whatever the value of `crc4_en`.
- R5: `crc_err` and `ebit_err` add to their tallies only in cycles where `crc4_en` is 1. When `crc4_en` is 0 they are ignored.
- R6: Each tally saturates at 2^W-1 (1023 for the default 10-bit width) and does not wrap.
- R7: A strobe that is high in the last cycle of an interval, the cycle in which the boundary is taken, is counted in the new interval and not in the total being latched.
- R8: A held total of width W appears with its bits 7..0 on the `_lo` byte. Its bits W-1..8 appear on the `_hi` byte starting at bit 0, and the unused upper bits of `_hi` are zero.
- R9: The three tallies are independent. A strobe on one input never changes another input's total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock (2.048 MHz in service) |
| rst_n | input | 1 | Active-low synchronous reset |
| crc4_en | input | 1 | CRC4 multiframe mode; enables the CRC and E-bit tallies |
| bpv_err | input | 1 | One-cycle bipolar violation strobe |
| crc_err | input | 1 | One-cycle CRC4 checksum error strobe |
| ebit_err | input | 1 | One-cycle far-end E-bit error strobe |
| bpv_hi | output | 8 | Held bipolar violation total, upper part |
| bpv_lo | output | 8 | Held bipolar violation total, bits 7..0 |
| crc_hi | output | 8 | Held CRC4 error total, upper part |
| crc_lo | output | 8 | Held CRC4 error total, bits 7..0 |
| ebit_hi | output | 8 | Held E-bit error total, upper part |
| ebit_lo | output | 8 | Held E-bit error total, bits 7..0 |
| sec_flag | output | 1 | One-cycle pulse: new totals have just been latched |

## Verification
The assertions check on every cycle that `sec_flag` repeats exactly every `TICK_DIV` cycles. They also check that no held byte moves outside a flag cycle. For each tally, they check that the latched total is nonzero exactly when some counted strobe was seen in the interval just closed. Exact totals cannot be shown this way and rely on the bench scenarios: totals above 255 that cross into the high byte, saturation at 1023, strobes arriving in the boundary cycle, and the effect of turning CRC4 mode on and off partway through a second.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/lec_sec_divider.sv
module lec_sec_divider #(
  parameter int DIV = 2048000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] phase_q;

  assign tick_o = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + DW'(1);
  end
endmodule

// File: rtl/lec_sat_counter.sv
module lec_sat_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         boundary_i,
  output logic [W-1:0] held_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      held_o <= '0;
    end else if (boundary_i) begin
      held_o <= run_q;
      run_q  <= inc_i ? W'(1) : '0;
    end else if (inc_i && (run_q != TOP)) begin
      run_q  <= run_q + W'(1);
    end
  end
endmodule

// File: rtl/lec_byte_split.sv
module lec_byte_split
  import lec_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] val_i,
  output byte_t        hi_o,
  output byte_t        lo_o
);
  generate
    if (W <= BYTE_W) begin : g_narrow
      assign hi_o = '0;
      assign lo_o = byte_t'(val_i);
    end else if (W == 2 * BYTE_W) begin : g_full
      assign hi_o = val_i[W-1:BYTE_W];
      assign lo_o = val_i[BYTE_W-1:0];
    end else begin : g_mid
      assign hi_o = {{(2*BYTE_W-W){1'b0}}, val_i[W-1:BYTE_W]};
      assign lo_o = val_i[BYTE_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/line_err_counters.sv
module line_err_counters
  import lec_pkg::*;
#(
  parameter int TICK_DIV = 2048000,
  parameter int BPV_W    = 10,
  parameter int CRC_W    = 10,
  parameter int EBIT_W   = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  crc4_en,
  input  logic  bpv_err,
  input  logic  crc_err,
  input  logic  ebit_err,
  output byte_t bpv_hi,
  output byte_t bpv_lo,
  output byte_t crc_hi,
  output byte_t crc_lo,
  output byte_t ebit_hi,
  output byte_t ebit_lo,
  output logic  sec_flag
);
  logic              tick;
  logic [BPV_W-1:0]  bpv_held;
  logic [CRC_W-1:0]  crc_held;
  logic [EBIT_W-1:0] ebit_held;

  lec_sec_divider #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  lec_sat_counter #(.W(BPV_W)) u_bpv (
    .clk(clk), .rst_n(rst_n), .inc_i(bpv_err),
    .boundary_i(tick), .held_o(bpv_held)
  );

  lec_sat_counter #(.W(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .inc_i(crc_err & crc4_en),
    .boundary_i(tick), .held_o(crc_held)
  );

  lec_sat_counter #(.W(EBIT_W)) u_ebit (
    .clk(clk), .rst_n(rst_n), .inc_i(ebit_err & crc4_en),
    .boundary_i(tick), .held_o(ebit_held)
  );

  lec_byte_split #(.W(BPV_W)) u_bpv_split (
    .val_i(bpv_held), .hi_o(bpv_hi), .lo_o(bpv_lo)
  );

  lec_byte_split #(.W(CRC_W)) u_crc_split (
    .val_i(crc_held), .hi_o(crc_hi), .lo_o(crc_lo)
  );

  lec_byte_split #(.W(EBIT_W)) u_ebit_split (
    .val_i(ebit_held), .hi_o(ebit_hi), .lo_o(ebit_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sec_flag <= 1'b0;
    else        sec_flag <= tick;
  end
endmodule

// File: rtl/line_err_counters_chk.sv
module line_err_counters_chk #(
  parameter int DIV = 2048000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       crc4_en,
  input logic       bpv_err,
  input logic       crc_err,
  input logic       ebit_err,
  input logic [7:0] bpv_hi,
  input logic [7:0] bpv_lo,
  input logic [7:0] crc_hi,
  input logic [7:0] crc_lo,
  input logic [7:0] ebit_hi,
  input logic [7:0] ebit_lo,
  input logic       sec_flag
);
  localparam int CW = $clog2(DIV + 1);

  logic [CW-1:0] gap_q;
  logic          seen_bpv, seen_crc, seen_ebit;
  logic          last_cyc;

  assign last_cyc = (gap_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                   gap_q <= '0;
    else if (sec_flag)            gap_q <= CW'(1);
    else if (gap_q != CW'(DIV))   gap_q <= gap_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_bpv  <= 1'b0;
      seen_crc  <= 1'b0;
      seen_ebit <= 1'b0;
    end else if (last_cyc) begin
      seen_bpv  <= bpv_err;
      seen_crc  <= crc_err & crc4_en;
      seen_ebit <= ebit_err & crc4_en;
    end else begin
      seen_bpv  <= seen_bpv  | bpv_err;
      seen_crc  <= seen_crc  | (crc_err & crc4_en);
      seen_ebit <= seen_ebit | (ebit_err & crc4_en);
    end
  end

  AST_FLAG_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_flag == (gap_q == CW'(DIV))); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_flag |-> $stable({bpv_hi, bpv_lo, crc_hi, crc_lo, ebit_hi, ebit_lo})); // R3

  AST_BPV_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    sec_flag |-> (({bpv_hi, bpv_lo} != 16'd0) == $past(seen_bpv))); // R4

  AST_CRC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sec_flag |-> (({crc_hi, crc_lo} != 16'd0) == $past(seen_crc))); // R5

  AST_EBIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sec_flag |-> (({ebit_hi, ebit_lo} != 16'd0) == $past(seen_ebit))); // R5
endmodule

bind line_err_counters line_err_counters_chk #(.DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .crc4_en(crc4_en),
  .bpv_err(bpv_err), .crc_err(crc_err), .ebit_err(ebit_err),
  .bpv_hi(bpv_hi), .bpv_lo(bpv_lo), .crc_hi(crc_hi), .crc_lo(crc_lo),
  .ebit_hi(ebit_hi), .ebit_lo(ebit_lo), .sec_flag(sec_flag)
);

// File: tb/line_err_counters_tb_top.sv
`timescale 1ns/1ps
module line_err_counters_tb_top;
  localparam int DIV = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crc4_en = 1'b1;
  logic bpv_err = 1'b0;
  logic crc_err = 1'b0;
  logic ebit_err = 1'b0;
  logic [7:0] bpv_hi, bpv_lo, crc_hi, crc_lo, ebit_hi, ebit_lo;
  logic sec_flag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  line_err_counters #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .crc4_en(crc4_en),
    .bpv_err(bpv_err), .crc_err(crc_err), .ebit_err(ebit_err),
    .bpv_hi(bpv_hi), .bpv_lo(bpv_lo), .crc_hi(crc_hi), .crc_lo(crc_lo),
    .ebit_hi(ebit_hi), .ebit_lo(ebit_lo), .sec_flag(sec_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rd_bpv();  return int'({bpv_hi, bpv_lo});   endfunction
  function automatic int rd_crc();  return int'({crc_hi, crc_lo});   endfunction
  function automatic int rd_ebit(); return int'({ebit_hi, ebit_lo}); endfunction

  task automatic chk_all(input string req, input int eb, input int ec, input int ee);
    chk(rd_bpv()  == eb, {req, " bpv"},  rd_bpv(),  eb);
    chk(rd_crc()  == ec, {req, " crc"},  rd_crc(),  ec);
    chk(rd_ebit() == ee, {req, " ebit"}, rd_ebit(), ee);
  endtask

  task automatic wait_flag();
    do @(negedge clk); while (!sec_flag);
  endtask

  task automatic clear_strobes();
    bpv_err = 1'b0; crc_err = 1'b0; ebit_err = 1'b0;
  endtask

  // R1: reset state
  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk_all("R1 in reset", 0, 0, 0);
    chk(sec_flag == 1'b0, "R1 flag in reset", sec_flag, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk_all("R1 after release", 0, 0, 0);
    chk(sec_flag == 1'b0, "R1 flag after release", sec_flag, 0);
  endtask

  // R2: boundary spacing and one-cycle flag
  task automatic t_period();
    int n;
    wait_flag();
    @(negedge clk);
    chk(sec_flag == 1'b0, "R2 flag width", sec_flag, 0);
    n = 1;
    while (!sec_flag) begin
      @(negedge clk);
      n++;
    end
    chk(n == DIV, "R2 period", n, DIV);
  endtask

  // R4 R5 R8 R9: counts, byte split, independence
  task automatic t_basic();
    wait_flag();
    for (int i = 0; i < 400; i++) begin
      bpv_err  = (i < 300);
      crc_err  = (i < 90) && (i % 3 == 0);
      ebit_err = (i >= 100) && (i < 107);
      @(negedge clk);
    end
    clear_strobes();
    wait_flag();
    chk_all("R4 R9 pattern A", 300, 30, 7);
    chk(bpv_hi == 8'd1,  "R8 bpv hi", bpv_hi, 1);
    chk(bpv_lo == 8'd44, "R8 bpv lo", bpv_lo, 44);
    for (int i = 0; i < 300; i++) begin
      bpv_err = (i == 17);
      crc_err = (i < 256);
      @(negedge clk);
    end
    clear_strobes();
    wait_flag();
    chk_all("R9 pattern B", 1, 256, 0);
    chk(crc_hi == 8'd1 && crc_lo == 8'd0, "R8 crc split", int'({crc_hi, crc_lo}), 256);
  endtask

  // R5: CRC4 mode gating
  task automatic t_gate();
    wait_flag();
    for (int i = 0; i < 70; i++) begin
      crc4_en  = (i >= 50);
      bpv_err  = (i < 10);
      crc_err  = 1'b1;
      ebit_err = (i < 50) || (i < 55);
      @(negedge clk);
    end
    clear_strobes();
    crc4_en = 1'b1;
    wait_flag();
    chk_all("R5 gating", 10, 20, 5);
  endtask

  // R3: holds stay between boundaries, tallies restart
  task automatic t_hold();
    wait_flag();
    for (int i = 0; i < 40; i++) begin
      bpv_err = 1'b1;
      @(negedge clk);
    end
    clear_strobes();
    wait_flag();
    chk_all("R3 latched", 40, 0, 0);
    for (int i = 0; i < 600; i++) begin
      bpv_err = 1'b1;
      ebit_err = (i < 3);
      if (i == 300) chk_all("R3 mid-interval hold", 40, 0, 0);
      @(negedge clk);
    end
    clear_strobes();
    wait_flag();
    chk_all("R3 next interval", 600, 0, 3);
  endtask

  // R7: strobe in the boundary cycle goes to the new interval
  task automatic t_edge();
    wait_flag();
    repeat (DIV - 2) @(negedge clk);
    bpv_err = 1'b1;
    @(negedge clk);
    crc_err = 1'b1;
    @(negedge clk);
    clear_strobes();
    chk(sec_flag == 1'b1, "R7 boundary alignment", sec_flag, 1);
    chk_all("R7 old interval", 1, 0, 0);
    wait_flag();
    chk_all("R7 new interval", 1, 1, 0);
  endtask

  // R6: saturation
  task automatic t_sat();
    wait_flag();
    for (int i = 0; i < DIV - 1; i++) begin
      bpv_err = 1'b1; crc_err = 1'b1; ebit_err = 1'b1;
      @(negedge clk);
    end
    clear_strobes();
    wait_flag();
    chk_all("R6 saturate", 1023, 1023, 1023);
    chk(bpv_hi == 8'd3 && bpv_lo == 8'd255, "R6 R8 sat bytes", int'({bpv_hi, bpv_lo}), 1023);
    wait_flag();
    chk_all("R3 R6 restart after saturation", 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_basic();
    t_gate();
    t_hold();
    t_edge();
    t_sat();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule